// File: doc/BRIEF.md
# Processor I/O Port with Memory Bank Selects

This block is a small register pair mapped at two adjacent addresses inside a processor. One address holds a direction mask and the other holds an output value latch. Software writes these two registers through a simple synchronous bus: an address bit, a write strobe and an 8-bit write word. Read data comes back combinationally.

Three of the port bits leave the block as registered bank-select lines for the memory decoder. Port bit 0 chooses ROM or RAM in the low bank window, bit 1 does the same in the high bank window, and bit 2 chooses between I/O devices and the character ROM. A select line follows its latch bit only while the matching direction bit is 1. While that direction bit is 0, the line keeps the last value it took.

Top module: `cpu_port_banker`

## Requirements
- R1: While `rst_n` is low, the direction register holds 0xEF, the value latch holds 0x37, and all three select outputs are 1. These values hold until the first write after reset is released.
- R2: When `addr` = 0, `rd_data` equals the direction register, all 8 bits of it.
- R3: When `addr` = 1, `rd_data` equals (latch OR NOT direction) AND 0x3F. Bits 7 and 6 therefore always read 0, and any bit whose direction bit is 0 reads 1.
- R4: A write with `wr_en` = 1 stores the full 8-bit `wr_data`. It goes to the direction register when `addr` = 0 and to the latch when `addr` = 1.
- R5: `lo_rom_sel` follows port bit 0, `hi_rom_sel` follows port bit 1 and `char_io_sel` follows port bit 2. For `char_io_sel`, 1 means I/O devices and 0 means character ROM.
- R6: The select outputs take their new values on the same rising edge that stores the write.
- R7: A select output whose direction bit is 0 keeps its value when its latch bit is written with either polarity.
- R8: Writing the direction register re-evaluates the selects. Any output whose direction bit becomes 1 takes the latch bit that is already stored, with no latch write needed.
- R9: While `wr_en` = 0, neither register and no select output changes, whatever `addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | 0 = direction register, 1 = value latch |
| wr_data | input | 8 | Write word |
| rd_data | output | 8 | Combinational read word |
| lo_rom_sel | output | 1 | Low bank: 1 = ROM, 0 = RAM |
| hi_rom_sel | output | 1 | High bank: 1 = ROM, 0 = RAM |
| char_io_sel | output | 1 | 1 = I/O devices, 0 = character ROM |

## Verification
The hardest situation to reach is a select line that holds a value its latch bit no longer carries. To get there, the stimulus first drives a line with its direction bit set. It then clears only that direction bit and rewrites the latch with the bit inverted. The readback forces that bit to 1 at this point, so the held value can only be seen on the select pin. A later direction write that sets the bit again shows the stored latch bit reaching the pin without any latch write.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
  localparam int PORT_W = 8;
  localparam int BANK_N = 3;
  localparam logic [PORT_W-1:0] DIR_RST = 8'hEF;
  localparam logic [PORT_W-1:0] LAT_RST = 8'h37;
  localparam logic [PORT_W-1:0] RD_MASK = 8'h3F;
  typedef enum logic {SEL_DIR = 1'b0, SEL_LAT = 1'b1} port_addr_e;
endpackage

// File: rtl/port_regs.sv
module port_regs #(
  parameter int W = 8,
  parameter int N = 3,
  parameter logic [W-1:0] DIR_INIT = '0,
  parameter logic [W-1:0] LAT_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [N-1:0] dir_nx_lo,
  output logic [N-1:0] lat_nx_lo
);
  import cpu_port_pkg::*;

  logic [W-1:0] dir_d, lat_d;
  logic         dir_en, lat_en;

  // strobe decode
  always_comb begin
    dir_en = wr_en && (port_addr_e'(addr) == SEL_DIR);
    lat_en = wr_en && (port_addr_e'(addr) == SEL_LAT);
    dir_d  = dir_en ? wr_data : dir_q;
    lat_d  = lat_en ? wr_data : lat_q;
  end

  // the select flops need the post-write contents in the same cycle
  assign dir_nx_lo = dir_d[N-1:0];
  assign lat_nx_lo = lat_d[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_INIT;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= LAT_INIT;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/bank_select.sv
module bank_select #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [N-1:0] dir_nx,
  input  logic [N-1:0] lat_nx,
  output logic [N-1:0] sel_q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic load;
    always_comb load = upd && dir_nx[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= RST_VAL[i];
      end else if (load) begin
        sel_q[i] <= lat_nx[i];
      end
    end
  end
endmodule

// File: rtl/port_readback.sv
module port_readback #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         addr,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  output logic [W-1:0] rd_data
);
  import cpu_port_pkg::*;

  always_comb begin
    if (port_addr_e'(addr) == SEL_DIR) begin
      rd_data = dir_q;
    end else begin
      // bits configured as inputs float high
      rd_data = (lat_q | ~dir_q) & MASK;
    end
  end
endmodule

// File: rtl/cpu_port_banker.sv
module cpu_port_banker
  import cpu_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  output logic              lo_rom_sel,
  output logic              hi_rom_sel,
  output logic              char_io_sel
);
  // reset re-evaluation from a cleared state: only lines with direction set pick up the latch
  localparam logic [BANK_N-1:0] SEL_RST = DIR_RST[BANK_N-1:0] & LAT_RST[BANK_N-1:0];

  logic [PORT_W-1:0] dir_q, lat_q;
  logic [BANK_N-1:0] dir_nx, lat_nx, sel;

  port_regs #(
    .W(PORT_W), .N(BANK_N), .DIR_INIT(DIR_RST), .LAT_INIT(LAT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .dir_q(dir_q), .lat_q(lat_q), .dir_nx_lo(dir_nx), .lat_nx_lo(lat_nx)
  );

  bank_select #(
    .N(BANK_N), .RST_VAL(SEL_RST)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .upd(wr_en),
    .dir_nx(dir_nx), .lat_nx(lat_nx), .sel_q(sel)
  );

  port_readback #(
    .W(PORT_W), .MASK(RD_MASK)
  ) u_rd (
    .addr(addr), .dir_q(dir_q), .lat_q(lat_q), .rd_data(rd_data)
  );

  assign lo_rom_sel  = sel[0];
  assign hi_rom_sel  = sel[1];
  assign char_io_sel = sel[2];
endmodule

// File: rtl/cpu_port_chk.sv
module cpu_port_chk #(
  parameter int W = 8,
  parameter int N = 3,
  parameter logic [W-1:0] MASK = 8'h3F
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         addr,
  input logic [W-1:0] rd_data,
  input logic [N-1:0] sel,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] lat_q
);
  // R1
  sel_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&sel));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sel) && $stable(dir_q) && $stable(lat_q)));

  // R3
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> ((rd_data & ~MASK) == '0));

  // R2
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> (rd_data == dir_q));

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R8
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!dir_q[i] || (sel[i] == lat_q[i])));
    // R7
    sel_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && !dir_q[i]) |=> $stable(sel[i]));
  end
endmodule

bind cpu_port_banker cpu_port_chk #(
  .W(cpu_port_pkg::PORT_W), .N(cpu_port_pkg::BANK_N), .MASK(cpu_port_pkg::RD_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
  .sel({char_io_sel, hi_rom_sel, lo_rom_sel}), .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/test_cpu_port_banker.sv
`timescale 1ns/1ps
module test_cpu_port_banker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       lo_rom_sel, hi_rom_sel, char_io_sel;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_dir, m_lat;
  logic [2:0] m_sel;

  always #2.5 clk = ~clk;

  cpu_port_banker i_cpu_port_banker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .lo_rom_sel(lo_rom_sel), .hi_rom_sel(hi_rom_sel),
    .char_io_sel(char_io_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pins();
    return {char_io_sel, hi_rom_sel, lo_rom_sel};
  endfunction

  // model follows R3, R4, R8
  task automatic model_wr(input logic a, input logic [7:0] d);
    if (!a) m_dir = d; else m_lat = d;
    for (int i = 0; i < 3; i++) if (m_dir[i]) m_sel[i] = m_lat[i];
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic read_both(input string req);
    addr = 1'b0; #0.5;
    chk(req, rd_data, m_dir);
    addr = 1'b1; #0.5;
    chk(req, rd_data, (m_lat | ~m_dir) & 8'h3F);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_dir = 8'hEF; m_lat = 8'h37; m_sel = 3'b111;
    chk("R1 sel in reset", {5'd0, pins()}, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 1'b0; #0.5; chk("R1 dir", rd_data, 8'hEF);
    addr = 1'b1; #0.5; chk("R1 latch read", rd_data, 8'h37);
    chk("R1 sel after release", {5'd0, pins()}, 8'h07);
  endtask

  task automatic t_readback();
    bus_wr(1'b0, 8'hA5); read_both("R2 R4 dir A5");
    bus_wr(1'b1, 8'hC3);
    addr = 1'b1; #0.5; chk("R3 masked C3/A5", rd_data, 8'h1B);
    bus_wr(1'b0, 8'h00); read_both("R3 dir 00");
    addr = 1'b1; #0.5; chk("R3 all inputs", rd_data, 8'h3F);
    bus_wr(1'b0, 8'hFF); bus_wr(1'b1, 8'h00);
    addr = 1'b1; #0.5; chk("R3 all outputs zero", rd_data, 8'h00);
    bus_wr(1'b1, 8'hFF);
    addr = 1'b1; #0.5; chk("R3 top bits zero", rd_data, 8'h3F);
    addr = 1'b0; #0.5; chk("R4 dir full width", rd_data, 8'hFF);
  endtask

  task automatic t_mapping();
    bus_wr(1'b0, 8'h07);
    bus_wr(1'b1, 8'h01); chk("R5 bit0 lo", {5'd0, pins()}, 8'h01);
    bus_wr(1'b1, 8'h02); chk("R5 bit1 hi", {5'd0, pins()}, 8'h02);
    bus_wr(1'b1, 8'h04); chk("R5 bit2 char", {5'd0, pins()}, 8'h04);
    // R6: output must change right after the storing edge
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b1; wr_data = 8'h03;
    @(posedge clk); #0.5;
    chk("R6 same edge", {5'd0, pins()}, 8'h03);
    @(negedge clk); wr_en = 1'b0;
    model_wr(1'b1, 8'h03);
  endtask

  task automatic t_freeze();
    bus_wr(1'b0, 8'h07); bus_wr(1'b1, 8'h01);
    bus_wr(1'b0, 8'h06);
    bus_wr(1'b1, 8'h00);
    chk("R7 lo frozen high", {5'd0, pins()}, {5'd0, m_sel});
    chk("R7 lo value", {7'd0, lo_rom_sel}, 8'h01);
    bus_wr(1'b0, 8'h03); bus_wr(1'b1, 8'h03);
    bus_wr(1'b0, 8'h01);
    bus_wr(1'b1, 8'h04);
    chk("R7 hi held high, char held low", {5'd0, pins()}, 8'h02);
  endtask

  task automatic t_dir_reload();
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h05);
    chk("R8 no change with dir 00", {5'd0, pins()}, {5'd0, m_sel});
    bus_wr(1'b0, 8'h01);
    chk("R8 lo reload", {5'd0, pins()}, {5'd0, m_sel});
    chk("R8 lo value", {7'd0, lo_rom_sel}, 8'h01);
    bus_wr(1'b0, 8'h06);
    chk("R8 hi/char reload", {5'd0, pins()}, 8'h05);
  endtask

  task automatic t_idle();
    bus_wr(1'b0, 8'h07); bus_wr(1'b1, 8'h02);
    @(negedge clk);
    addr = 1'b1; wr_data = 8'h05;
    @(negedge clk);
    addr = 1'b0; wr_data = 8'h00;
    @(negedge clk);
    chk("R9 sel unchanged", {5'd0, pins()}, 8'h02);
    read_both("R9 regs unchanged");
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_readback();
    t_mapping();
    t_freeze();
    t_dir_reload();
    t_idle();
    do_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule